// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block collects single-cycle event pulses from up to eighteen on-chip sources into a sticky status register. It drives one interrupt line toward the host. A status bit stays set until the host clears it, so no event is lost between two host polls. A mask register decides which pending bits may raise the line. Bits that are masked are still recorded in status.

The host reaches the block through a simple synchronous strobe bus with byte offsets. It can:
- write the mask directly, or change single mask bits through separate set and clear aliases, so no read-modify-write is needed;
- look at status without changing it, or read it destructively;
- clear chosen status bits with a write-one acknowledge.

A small configuration register turns the interrupt output on and selects its polarity. Read data appears the cycle after the read strobe.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0x0000_0001, status reads 0, configuration reads 0, `rdata` is 0 and `irq_o` is low.
- R2: A 1 on an event input at an implemented position sets that status bit, which then stays set. The implemented positions are bits 0–10, 14, 16 and 17. Event inputs at bits 11, 12, 13 and 15 have no effect, and those status bits read 0.
- R3: A write to offset 0x00 loads the mask from `wdata`, keeping implemented positions only. Reading 0x00 returns the mask.
- R4: A write to offset 0x04 sets each mask bit written as 1 and leaves the other mask bits unchanged.
- R5: A write to offset 0x08 clears each mask bit written as 1 and leaves the other mask bits unchanged. Reads of 0x04 and 0x08 return 0.
- R6: A read of offset 0x0C returns status and leaves status unchanged.
- R7: A read of offset 0x10 returns status and clears every status bit in the same clock.
- R8: A write to offset 0x14 clears each status bit written as 1. Bits written as 0 are unaffected. The clear shows in both status views.
- R9: If an event arrives in the same cycle as a clear-on-read or an acknowledge of that bit, the bit ends up set.
- R10: The interrupt is pending when any status bit is set whose mask bit is 0. With configuration bit 0 (enable) set and bit 1 clear, `irq_o` is high exactly while an interrupt is pending.
- R11: With configuration bit 1 (active-low) set, `irq_o` is the inverse of the R10 level. While enable is 0, `irq_o` sits at its inactive level, which is low when bit 1 is 0 and high when bit 1 is 1. The configuration register sits at offset 0x18 and reads back bits 1:0.
- R12: `rdata` changes only on the clock edge that follows a read strobe and holds its value otherwise. Writes to offsets 0x0C and 0x10 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 18 | Event pulses, one per status bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_o | output | 1 | Host interrupt line |

## Verification
The hardest case to reach is an event that lands in the very cycle the host clears the same bit. A loosely timed host would almost never hit that window. The bench therefore drives the event pulse and the clear-on-read strobe, or the acknowledge write, on the same negative edge. It then reads the non-destructive view to show that the bit survived while its neighbours were cleared. A cycle-level model in the bench follows every register and checks `rdata` and `irq_o` after each clock, so polarity and mask changes are also checked in the cycles between the explicit reads.

// File: rtl/hirq_pkg.sv
// Package: shared constants and types for the host interrupt controller.
// Assumes a 32-bit register bus with byte offsets.
package hirq_pkg;

    localparam int HIRQ_DW = 32;

    // Offsets of the host-visible registers
    localparam logic [7:0] OFF_MASK = 8'h00;
    localparam logic [7:0] OFF_MSET = 8'h04;
    localparam logic [7:0] OFF_MCLR = 8'h08;
    localparam logic [7:0] OFF_STAT = 8'h0C;
    localparam logic [7:0] OFF_STCR = 8'h10;
    localparam logic [7:0] OFF_ACK  = 8'h14;
    localparam logic [7:0] OFF_CFG  = 8'h18;

    // Configuration bit positions
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_LOW_BIT = 1;
    localparam logic [HIRQ_DW-1:0] CFG_USED = 32'h0000_0003;

    // Decoded one-cycle bus requests
    typedef struct packed {
        logic mask_wr;
        logic mask_set;
        logic mask_clr;
        logic ack_wr;
        logic cor_rd;
        logic cfg_wr;
    } hirq_req_t;

    // Read source selection
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_MASK = 2'd1,
        RSEL_STAT = 2'd2,
        RSEL_CFG  = 2'd3
    } hirq_rsel_t;

endpackage

// File: rtl/hirq_regif.sv
// Module: hirq_regif
// Decodes bus strobes into per-register requests and registers the read data.
// Assumes at most one access per cycle. A simultaneous read and write are
// decoded independently. Unmapped offsets read 0 and ignore writes.
module hirq_regif
    import hirq_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [HIRQ_DW-1:0] mask_q,
    input  logic [HIRQ_DW-1:0] stat_q,
    input  logic [HIRQ_DW-1:0] cfg_q,
    output hirq_req_t          req,
    output logic [HIRQ_DW-1:0] rdata
);

    hirq_rsel_t         rsel;
    logic [HIRQ_DW-1:0] rd_mux;

    // Write and destructive-read decode
    always_comb begin
        req          = '0;
        req.mask_wr  = wr_en && (addr == OFF_MASK[ADDR_W-1:0]);
        req.mask_set = wr_en && (addr == OFF_MSET[ADDR_W-1:0]);
        req.mask_clr = wr_en && (addr == OFF_MCLR[ADDR_W-1:0]);
        req.ack_wr   = wr_en && (addr == OFF_ACK[ADDR_W-1:0]);
        req.cfg_wr   = wr_en && (addr == OFF_CFG[ADDR_W-1:0]);
        req.cor_rd   = rd_en && (addr == OFF_STCR[ADDR_W-1:0]);
    end

    // Read source select
    always_comb begin
        if (addr == OFF_MASK[ADDR_W-1:0])
            rsel = RSEL_MASK;
        else if (addr == OFF_STAT[ADDR_W-1:0] || addr == OFF_STCR[ADDR_W-1:0])
            rsel = RSEL_STAT;
        else if (addr == OFF_CFG[ADDR_W-1:0])
            rsel = RSEL_CFG;
        else
            rsel = RSEL_NONE;
    end

    // Read data multiplexer
    always_comb begin
        case (rsel)
            RSEL_MASK: rd_mux = mask_q;
            RSEL_STAT: rd_mux = stat_q;
            RSEL_CFG:  rd_mux = cfg_q;
            default:   rd_mux = '0;
        endcase
    end

    // Read data register, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    // R12: rdata holds when no read strobe was seen
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/hirq_mask.sv
// Module: hirq_mask
// Holds the interrupt mask, writable directly or through atomic set and
// clear aliases. Only implemented positions can hold a 1.
module hirq_mask
    import hirq_pkg::*;
#(
    parameter logic [HIRQ_DW-1:0] IMPL    = 32'h0003_47FF,
    parameter logic [HIRQ_DW-1:0] RST_VAL = 32'h0000_0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  hirq_req_t          req,
    input  logic [HIRQ_DW-1:0] wdata,
    output logic [HIRQ_DW-1:0] mask_q
);

    localparam logic [HIRQ_DW-1:0] RST_EFF = RST_VAL & IMPL;

    logic [HIRQ_DW-1:0] mask_d;

    // Next mask from the three write paths
    always_comb begin
        mask_d = mask_q;
        if (req.mask_wr)
            mask_d = wdata;
        else if (req.mask_set)
            mask_d = mask_q | wdata;
        else if (req.mask_clr)
            mask_d = mask_q & ~wdata;
        mask_d = mask_d & IMPL;
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= RST_EFF;
        else
            mask_q <= mask_d;
    end

    // R3: direct write loads implemented bits
    a_r3_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        req.mask_wr |=> (mask_q == ($past(wdata) & IMPL)));
    // R4: set alias raises every written 1
    a_r4_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        req.mask_set |=> ((mask_q & $past(wdata & IMPL)) == $past(wdata & IMPL)));
    // R5: clear alias drops every written 1
    a_r5_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        req.mask_clr |=> ((mask_q & $past(wdata)) == '0));

endmodule

// File: rtl/hirq_status.sv
// Module: hirq_status
// Sticky event status. Events set bits; clear-on-read clears all bits,
// acknowledge clears selected bits. An event in the same cycle beats a clear.
module hirq_status
    import hirq_pkg::*;
#(
    parameter int                 EVT_W = 18,
    parameter logic [HIRQ_DW-1:0] IMPL  = 32'h0003_47FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVT_W-1:0]   evt_i,
    input  hirq_req_t          req,
    input  logic [HIRQ_DW-1:0] wdata,
    output logic [HIRQ_DW-1:0] stat_q
);

    logic [HIRQ_DW-1:0] evt_w;
    logic [HIRQ_DW-1:0] clr_w;

    // Widen events to the register width and drop reserved positions
    always_comb begin
        evt_w = {{(HIRQ_DW-EVT_W){1'b0}}, evt_i} & IMPL;
    end

    // Clear vector from clear-on-read and acknowledge
    always_comb begin
        clr_w = '0;
        if (req.ack_wr)
            clr_w = wdata;
        if (req.cor_rd)
            clr_w = '1;
    end

    // Status register, event has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_w) | evt_w;
    end

    // R2: with no clear request no status bit falls
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(req.cor_rd || req.ack_wr) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    // R9: every arriving event is set afterwards regardless of clears
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_w != '0) |=> ((stat_q & $past(evt_w)) == $past(evt_w)));
    // R7: a destructive read with no event leaves status empty
    a_r7_cor_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (req.cor_rd && evt_i == '0) |=> (stat_q == '0));
    // R8: acknowledge alone clears exactly the written bits
    a_r8_ack_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (req.ack_wr && !req.cor_rd && evt_i == '0) |=>
            (stat_q == ($past(stat_q) & ~$past(wdata))));

endmodule

// File: rtl/hirq_out.sv
// Module: hirq_out
// Configuration register and host interrupt line generation.
// IRQ_REG selects a registered output (one cycle later) or a direct one.
module hirq_out
    import hirq_pkg::*;
#(
    parameter bit IRQ_REG = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  hirq_req_t          req,
    input  logic [HIRQ_DW-1:0] wdata,
    input  logic [HIRQ_DW-1:0] stat_q,
    input  logic [HIRQ_DW-1:0] mask_q,
    output logic [HIRQ_DW-1:0] cfg_q,
    output logic               irq_o
);

    logic pending;
    logic level;
    logic cfg_en;
    logic cfg_low;

    // Configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (req.cfg_wr)
            cfg_q <= wdata & CFG_USED;
    end

    // Pending detection and polarity
    always_comb begin
        cfg_en  = cfg_q[CFG_EN_BIT];
        cfg_low = cfg_q[CFG_LOW_BIT];
        pending = |(stat_q & ~mask_q);
        level   = cfg_en ? (pending ^ cfg_low) : cfg_low;
    end

    generate
        if (IRQ_REG) begin : g_irq_reg
            logic irq_q;
            // Registered output stage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    irq_q <= 1'b0;
                else
                    irq_q <= level;
            end
            assign irq_o = irq_q;
        end else begin : g_irq_comb
            assign irq_o = level;
        end
    endgenerate

    // R10: with nothing unmasked pending the line is at its inactive level
    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~mask_q) == '0) |-> (level == cfg_q[CFG_LOW_BIT]));
    // R11: disabled output holds the inactive level for its polarity
    a_r11_disabled_level: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[CFG_EN_BIT] |-> (level == cfg_q[CFG_LOW_BIT]));

endmodule

// File: rtl/host_irq_ctrl.sv
// Module: host_irq_ctrl
// Top of the host interrupt status controller: decode, mask, status and output.
// Assumes events and bus are synchronous to clk.
module host_irq_ctrl
    import hirq_pkg::*;
#(
    parameter int                 EVT_W     = 18,
    parameter int                 ADDR_W    = 5,
    parameter logic [HIRQ_DW-1:0] IMPL_MASK = 32'h0003_47FF,
    parameter logic [HIRQ_DW-1:0] MASK_RST  = 32'h0000_0001,
    parameter bit                 IRQ_REG   = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVT_W-1:0]   evt_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [HIRQ_DW-1:0] wdata,
    output logic [HIRQ_DW-1:0] rdata,
    output logic               irq_o
);

    localparam logic [HIRQ_DW-1:0] EVT_SPAN = (EVT_W >= HIRQ_DW) ? '1 :
                                              ((HIRQ_DW'(1) << EVT_W) - HIRQ_DW'(1));
    localparam logic [HIRQ_DW-1:0] IMPL     = IMPL_MASK & EVT_SPAN;

    hirq_req_t          req;
    logic [HIRQ_DW-1:0] mask_q;
    logic [HIRQ_DW-1:0] stat_q;
    logic [HIRQ_DW-1:0] cfg_q;

    hirq_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .mask_q (mask_q),
        .stat_q (stat_q),
        .cfg_q  (cfg_q),
        .req    (req),
        .rdata  (rdata)
    );

    hirq_mask #(.IMPL(IMPL), .RST_VAL(MASK_RST)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .wdata  (wdata),
        .mask_q (mask_q)
    );

    hirq_status #(.EVT_W(EVT_W), .IMPL(IMPL)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .req    (req),
        .wdata  (wdata),
        .stat_q (stat_q)
    );

    hirq_out #(.IRQ_REG(IRQ_REG)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .wdata  (wdata),
        .stat_q (stat_q),
        .mask_q (mask_q),
        .cfg_q  (cfg_q),
        .irq_o  (irq_o)
    );

    // R2: reserved status positions never become set
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q | mask_q) & ~IMPL) == '0);

endmodule

// File: tb/host_irq_ctrl_tb.sv
// Bench: behavioural cycle model compared on every clock, plus literal checks.
module host_irq_ctrl_tb;

    localparam logic [31:0] IMPL = 32'h0003_47FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] evt = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_mask, m_stat, m_cfg, m_rdata;

    always #2 clk = ~clk;   // 250 MHz

    host_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq)
    );

    function automatic logic model_irq();
        logic pend;
        pend = (m_stat & ~m_mask) != 0;
        return m_cfg[0] ? (pend ^ m_cfg[1]) : m_cfg[1];
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One bus/event cycle, model update and compare at the next negedge
    task automatic step(input logic [17:0] e, input logic w, input logic r,
                        input logic [4:0] a, input logic [31:0] d, input string tag);
        logic [31:0] clr;
        evt = e; wr_en = w; rd_en = r; addr = a; wdata = d;
        @(posedge clk);
        if (r) begin
            case (a)
                5'h00:        m_rdata = m_mask;
                5'h0C, 5'h10: m_rdata = m_stat;
                5'h18:        m_rdata = m_cfg;
                default:      m_rdata = 32'h0;
            endcase
        end
        clr = 32'h0;
        if (w && a == 5'h14) clr = d;
        if (r && a == 5'h10) clr = 32'hFFFF_FFFF;
        m_stat = (m_stat & ~clr) | ({14'h0, e} & IMPL);
        if (w) begin
            case (a)
                5'h00: m_mask = d & IMPL;
                5'h04: m_mask = (m_mask | d) & IMPL;
                5'h08: m_mask = m_mask & ~d;
                5'h18: m_cfg  = d & 32'h3;
                default: ;
            endcase
        end
        @(negedge clk);
        evt = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
        check(rdata === m_rdata, {tag, " R12 rdata"}, rdata, m_rdata);
        check(irq === model_irq(), {tag, " irq"}, {31'h0, irq}, {31'h0, model_irq()});
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        step('0, 1'b0, 1'b1, a, 32'h0, tag);
        check(rdata === exp, tag, rdata, exp);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
        step('0, 1'b1, 1'b0, a, d, tag);
    endtask

    task automatic irq_is(input logic exp, input string tag);
        check(irq === exp, tag, {31'h0, irq}, {31'h0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R12: got hang expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m_mask = 32'h1; m_stat = 0; m_cfg = 0; m_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rdata === 32'h0, "R1 rdata", rdata, 32'h0);
        irq_is(1'b0, "R1 irq");
        rd(5'h00, 32'h1, "R1 mask");
        rd(5'h18, 32'h0, "R1 cfg");
        rd(5'h0C, 32'h0, "R1 status");

        // R2 latching, masked bit 0 still recorded
        step(18'h00001, 1'b0, 1'b0, 5'h0, 32'h0, "R2");
        rd(5'h0C, 32'h1, "R2 bit0 latched");
        wr(5'h18, 32'h1, "R10 enable");
        irq_is(1'b0, "R10 masked bit quiet");
        step(18'h00002, 1'b0, 1'b0, 5'h0, 32'h0, "R10");
        irq_is(1'b1, "R10 unmasked pending");
        rd(5'h0C, 32'h3, "R6 first view");
        rd(5'h0C, 32'h3, "R6 second view");
        step(18'h0B800, 1'b0, 1'b0, 5'h0, 32'h0, "R2 reserved");
        rd(5'h0C, 32'h3, "R2 reserved ignored");

        // R8 acknowledge
        wr(5'h14, 32'h0, "R8 zero ack");
        rd(5'h0C, 32'h3, "R8 zero no effect");
        wr(5'h14, 32'h2, "R8 ack bit1");
        irq_is(1'b0, "R8 irq drops");
        rd(5'h0C, 32'h1, "R8 bit1 cleared");

        // R3 R4 R5 mask paths
        wr(5'h00, 32'hFFFF_FFFF, "R3");
        rd(5'h00, IMPL, "R3 implemented only");
        wr(5'h08, 32'h1, "R5");
        rd(5'h00, IMPL & ~32'h1, "R5 clear one");
        irq_is(1'b1, "R5 unmask raises irq");
        wr(5'h04, 32'h1, "R4");
        irq_is(1'b0, "R4 mask again");
        rd(5'h00, IMPL, "R4 set one");
        rd(5'h04, 32'h0, "R5 set alias reads 0");
        rd(5'h08, 32'h0, "R5 clr alias reads 0");
        wr(5'h00, 32'h0, "R3 zero");
        rd(5'h00, 32'h0, "R3 readback");

        // R7 clear on read
        step(18'h20420, 1'b0, 1'b0, 5'h0, 32'h0, "R7");
        rd(5'h10, 32'h20421, "R7 destructive view");
        rd(5'h0C, 32'h0, "R7 cleared");
        irq_is(1'b0, "R7 irq idle");

        // R9 collisions
        step(18'h00010, 1'b0, 1'b1, 5'h10, 32'h0, "R9 cor");
        check(rdata === 32'h0, "R9 cor old view", rdata, 32'h0);
        rd(5'h0C, 32'h10, "R9 event beats cor");
        step(18'h04000, 1'b1, 1'b0, 5'h14, 32'h4010, "R9 ack");
        rd(5'h0C, 32'h4000, "R9 event beats ack");

        // R11 polarity
        irq_is(1'b1, "R11 active high pending");
        wr(5'h18, 32'h3, "R11");
        irq_is(1'b0, "R11 active low pending");
        wr(5'h18, 32'h2, "R11");
        irq_is(1'b1, "R11 disabled low idle");
        wr(5'h18, 32'h0, "R11");
        irq_is(1'b0, "R11 disabled high idle");
        wr(5'h18, 32'h3, "R11");
        wr(5'h14, 32'h4000, "R11 ack");
        irq_is(1'b1, "R11 active low idle");
        rd(5'h18, 32'h3, "R11 cfg readback");

        // R12 read-only views ignore writes, rdata holds
        step(18'h00008, 1'b0, 1'b0, 5'h0, 32'h0, "R12");
        wr(5'h10, 32'h8, "R12 write cor view");
        wr(5'h0C, 32'hFFFF_FFFF, "R12 write nd view");
        rd(5'h0C, 32'h8, "R12 status unchanged");
        step('0, 1'b0, 1'b0, 5'h0, 32'h0, "R12 idle");
        step('0, 1'b1, 1'b0, 5'h18, 32'h1, "R12 idle write");
        check(rdata === 32'h8, "R12 rdata held", rdata, 32'h8);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule